// File: doc/BRIEF.md
# Firmware Hub Memory Read Target

This block is the target side of a single-byte memory read on a shared 4-bit, nibble-serial firmware bus. It samples the bus on every rising clock edge. It stays idle until it sees a read start code while the frame strobe is low. It then takes one device-select nibble, which it compares with its strapped identity, followed by seven address nibbles and one size nibble. If the select matches and the size asks for one byte, the block takes the bus. It sends a ready code and then the byte, low nibble first. Finally it drives all ones and releases the bus.

On the storage side there is a simple byte port. The block gives the low address bits and a one-cycle read strobe. The storage returns the byte on the clock after the strobe and holds it until the next strobe. A complete read takes 17 bus clocks. The host can begin the next start code in the clock right after the release clock.

Top module: `fwh_read_target`

## Requirements
- R1: While rst_n is low, the state machine is held idle, bus_oe is 0 and mem_rd is 0. An assertion of rst_n in the middle of a transfer drops bus_oe at once.
- R2: A read begins only when bus_in equals 4'b1101 in a clock where frame_n is 0. The value 4'b1101 with frame_n high, or any other nibble with frame_n low, leaves the target idle.
- R3: The nibble in the clock after the start is the select. If it differs from id_strap, the target never sets bus_oe and accepts a new start from the next clock on.
- R4: The next seven nibbles form a 28-bit address, most-significant nibble first. mem_addr carries the address's low AW bits, and address bits at or above AW have no effect on the returned byte.
- R5: mem_rd is high for exactly one clock: the size-nibble clock (clock 10) of a read whose select matched. mem_addr holds the full low-order address in that clock and stays unchanged until the next read's address nibbles.
- R6: If the size nibble in clock 10 is not 4'b0000, bus_oe stays 0 for the rest of the cycle.
- R7: In clock 11 bus_oe is 0. In clock 12 the target sets bus_oe and drives 4'b1111.
- R8: In clock 13 the target drives the ready code 4'b0000.
- R9: In clocks 14 and 15 the target drives bits [3:0] and then bits [7:4] of the mem_data byte that is valid in clock 11.
- R10: In clock 16 the target drives 4'b1111. In clock 17 bus_oe is 0, and a start code in clock 18 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| bus_in | input | 4 | Nibble sampled from the shared bus |
| id_strap | input | 4 | Strapped device identity |
| bus_out | output | 4 | Nibble driven when bus_oe is high |
| bus_oe | output | 1 | Bus driver enable |
| mem_addr | output | AW | Byte address to storage |
| mem_rd | output | 1 | One-clock read strobe to storage |
| mem_data | input | 8 | Byte returned by storage, one clock after the strobe |

## Verification
On every cycle, the assertions check the following: the fixed five-clock drive sequence with its ready and all-ones codes, the single-clock strobe, the address holding steady after the strobe, the return to idle after a select or size mismatch, and that every drive window follows a strobe. Only the bench scenarios can show the rest. This covers that the correct nibbles, in the correct order, land at the bus and on the storage address, and that the upper address bits make no difference. It also covers that a frame-high or unknown start is ignored, that reads can follow back to back, and that a reset in mid-transfer drops the driver.

// File: rtl/fwh_pkg.sv
`timescale 1ns/1ps
package fwh_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR,
    ST_SIZE,
    ST_TAR0,
    ST_TAR1,
    ST_SYNC,
    ST_DLO,
    ST_DHI,
    ST_REL0,
    ST_REL1
  } fwh_state_e;

  localparam logic [3:0] NIB_START_READ = 4'b1101;
  localparam logic [3:0] NIB_READY      = 4'b0000;
  localparam logic [3:0] NIB_ONE_BYTE   = 4'b0000;
  localparam logic [3:0] NIB_HIGH       = 4'b1111;

  // Start is valid only with the frame strobe low
  function automatic logic is_read_start(input logic frame_n, input logic [3:0] nib);
    return (!frame_n) && (nib == NIB_START_READ);
  endfunction

  // Data nibble order: low half first, high half second
  function automatic logic [3:0] pick_nibble(input logic [7:0] b, input logic upper);
    return upper ? b[7:4] : b[3:0];
  endfunction

endpackage

// File: rtl/fwh_phase_fsm.sv
`timescale 1ns/1ps
module fwh_phase_fsm
  import fwh_pkg::*;
#(
  parameter int ADDR_NIBS = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic [3:0]  bus_in,
  input  logic [3:0]  id_strap,
  output fwh_state_e  state,
  output logic        addr_phase,
  output logic        sel_miss,
  output logic        size_bad
);

  localparam int CW = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;
  localparam logic [CW-1:0] LAST_NIB = CW'(ADDR_NIBS - 1);

  fwh_state_e      nxt;
  logic [CW-1:0]   nib_cnt;
  logic            sel_hit;
  logic            size_ok;
  logic            start_seen;

  assign start_seen = (state == ST_IDLE) && is_read_start(frame_n, bus_in);
  assign sel_hit    = (state == ST_SEL)  && (bus_in == id_strap);
  assign sel_miss   = (state == ST_SEL)  && (bus_in != id_strap);
  assign size_ok    = (state == ST_SIZE) && (bus_in == NIB_ONE_BYTE);
  assign size_bad   = (state == ST_SIZE) && (bus_in != NIB_ONE_BYTE);
  assign addr_phase = (state == ST_ADDR);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start_seen) nxt = ST_SEL;
      ST_SEL:  nxt = sel_hit ? ST_ADDR : ST_IDLE;
      ST_ADDR: if (nib_cnt == LAST_NIB) nxt = ST_SIZE;
      ST_SIZE: nxt = size_ok ? ST_TAR0 : ST_IDLE;
      ST_TAR0: nxt = ST_TAR1;
      ST_TAR1: nxt = ST_SYNC;
      ST_SYNC: nxt = ST_DLO;
      ST_DLO:  nxt = ST_DHI;
      ST_DHI:  nxt = ST_REL0;
      ST_REL0: nxt = ST_REL1;
      ST_REL1: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      nib_cnt <= '0;
    end else begin
      state   <= nxt;
      nib_cnt <= addr_phase ? nib_cnt + CW'(1) : '0;
    end
  end

  p_start_needs_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEL) |-> ($past(!frame_n) && $past(bus_in) == NIB_START_READ));

  p_sel_miss_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_miss |=> (state == ST_IDLE));

  p_size_bad_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    size_bad |=> (state == ST_IDLE));

endmodule

// File: rtl/fwh_addr_collect.sv
`timescale 1ns/1ps
module fwh_addr_collect #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic [3:0]    nib,
  output logic [AW-1:0] addr
);

  // Most-significant nibble arrives first; only the low AW bits are kept
  function automatic logic [AW-1:0] shift_nibble(input logic [AW-1:0] cur, input logic [3:0] n);
    return AW'({cur, n});
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr <= '0;
    else if (shift_en) addr <= shift_nibble(addr, nib);
  end

  p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(shift_en) |-> $stable(addr));

endmodule

// File: rtl/fwh_bus_driver.sv
`timescale 1ns/1ps
module fwh_bus_driver
  import fwh_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  fwh_state_e  state,
  input  logic [7:0]  mem_data,
  output logic [3:0]  bus_out,
  output logic        bus_oe
);

  logic [7:0] byte_q;
  logic       capture;

  assign capture = (state == ST_TAR0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (capture) byte_q <= mem_data;
  end

  always_comb begin
    bus_oe  = 1'b0;
    bus_out = NIB_HIGH;
    unique case (state)
      ST_TAR1: begin bus_oe = 1'b1; bus_out = NIB_HIGH;                   end
      ST_SYNC: begin bus_oe = 1'b1; bus_out = NIB_READY;                  end
      ST_DLO:  begin bus_oe = 1'b1; bus_out = pick_nibble(byte_q, 1'b0); end
      ST_DHI:  begin bus_oe = 1'b1; bus_out = pick_nibble(byte_q, 1'b1); end
      ST_REL0: begin bus_oe = 1'b1; bus_out = NIB_HIGH;                   end
      default: begin bus_oe = 1'b0; bus_out = NIB_HIGH;                   end
    endcase
  end

  p_drive_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> (bus_out == NIB_HIGH)
      ##1 (bus_oe && bus_out == NIB_READY)
      ##1 bus_oe ##1 bus_oe
      ##1 (bus_oe && bus_out == NIB_HIGH)
      ##1 !bus_oe);

  p_byte_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DLO) |=> $stable(byte_q));

endmodule

// File: rtl/fwh_read_target.sv
`timescale 1ns/1ps
module fwh_read_target
  import fwh_pkg::*;
#(
  parameter int AW        = 18,
  parameter int ADDR_NIBS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic [3:0]    bus_in,
  input  logic [3:0]    id_strap,
  output logic [3:0]    bus_out,
  output logic          bus_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [7:0]    mem_data
);

  fwh_state_e state;
  logic       addr_phase;
  logic       sel_miss;
  logic       size_bad;

  fwh_phase_fsm #(.ADDR_NIBS(ADDR_NIBS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .bus_in     (bus_in),
    .id_strap   (id_strap),
    .state      (state),
    .addr_phase (addr_phase),
    .sel_miss   (sel_miss),
    .size_bad   (size_bad)
  );

  fwh_addr_collect #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (addr_phase),
    .nib      (bus_in),
    .addr     (mem_addr)
  );

  fwh_bus_driver u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .mem_data (mem_data),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe)
  );

  // Strobe in the size clock: address is complete, byte is ready before data
  assign mem_rd = (state == ST_SIZE);

  p_rd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  p_addr_after_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> $stable(mem_addr));

  p_oe_after_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(mem_rd, 2));

  p_no_oe_after_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_miss |=> !bus_oe);

endmodule

// File: tb/sim_fwh_read_target.sv
`timescale 1ns/1ps
module sim_fwh_read_target;

  localparam int AW = 18;
  localparam logic [3:0] MY_ID = 4'h6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_n = 1'b1;
  logic [3:0]    bus_in = 4'hF;
  logic [3:0]    bus_out;
  logic          bus_oe;
  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic [7:0]    mem_data = 8'h00;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fwh_read_target #(.AW(AW), .ADDR_NIBS(7)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in),
    .id_strap(MY_ID), .bus_out(bus_out), .bus_oe(bus_oe),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_data(mem_data)
  );

  // Storage content computed from the address
  function automatic logic [7:0] store_byte(input logic [AW-1:0] a);
    int v;
    v = int'(a);
    return 8'((v * 37) ^ (v >> 7) ^ 8'hC3);
  endfunction

  always @(posedge clk) if (mem_rd) mem_data <= store_byte(mem_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One bus clock: drive, compare at the falling edge, then pass the rising edge
  task automatic step(input logic [3:0] nib, input logic fr, input bit e_oe,
                      input logic [3:0] e_out, input bit e_rd,
                      input logic [AW-1:0] e_addr, input string req);
    bus_in  = nib;
    frame_n = fr;
    @(negedge clk);
    chk({req, " oe"}, 32'(bus_oe), 32'(e_oe));
    if (e_oe) chk({req, " data"}, 32'(bus_out), 32'(e_out));
    chk({req, " rd"}, 32'(mem_rd), 32'(e_rd));
    if (e_rd) chk({req, " addr"}, 32'(mem_addr), 32'(e_addr));
    @(posedge clk);
    #1;
  endtask

  // Reference model of one 17-clock read
  task automatic read_cycle(input logic [3:0] sel, input logic [27:0] a,
                            input logic [3:0] size, input bit fr_ok);
    bit hit;
    bit go;
    logic [AW-1:0] la;
    logic [7:0] d;
    hit = fr_ok && (sel == MY_ID);
    go  = hit && (size == 4'h0);
    la  = a[AW-1:0];
    d   = store_byte(la);
    step(4'hD, fr_ok ? 1'b0 : 1'b1, 0, 4'h0, 0, '0, "R2 start");
    step(sel, 1'b1, 0, 4'h0, 0, '0, "R3 select");
    for (int i = 6; i >= 0; i--) step(a[i*4 +: 4], 1'b1, 0, 4'h0, 0, '0, "R4 address");
    step(size, 1'b1, 0, 4'h0, hit, la, "R5 strobe");
    step(4'hF, 1'b1, 0, 4'h0, 0, '0, "R7 tar0");
    step(4'hF, 1'b1, go, 4'hF, 0, '0, "R7 tar1");
    step(4'hF, 1'b1, go, 4'h0, 0, '0, "R8 sync");
    step(4'hF, 1'b1, go, d[3:0], 0, '0, "R9 low nibble");
    step(4'hF, 1'b1, go, d[7:4], 0, '0, "R9 high nibble");
    step(4'hF, 1'b1, go, 4'hF, 0, '0, "R10 high drive");
    step(4'hF, 1'b1, 0, 4'h0, 0, '0, "R10 release");
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [27:0] lcg;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 reset oe", 32'(bus_oe), 32'd0);
    chk("R1 reset rd", 32'(mem_rd), 32'd0);
    rst_n = 1'b1;
    step(4'hF, 1'b1, 0, 4'h0, 0, '0, "R1 idle");

    // Main reads, back to back (R10: start right after release)
    read_cycle(MY_ID, 28'h1234567, 4'h0, 1'b1);
    read_cycle(MY_ID, 28'h0000000, 4'h0, 1'b1);
    read_cycle(MY_ID, 28'hFFFFFFF, 4'h0, 1'b1);

    // R4: upper address bits make no difference
    read_cycle(MY_ID, 28'hABC5A5A, 4'h0, 1'b1);
    read_cycle(MY_ID, 28'h0045A5A, 4'h0, 1'b1);

    // R3: select mismatch, then a valid read
    read_cycle(4'h9, 28'h0011223, 4'h0, 1'b1);
    read_cycle(MY_ID, 28'h0011223, 4'h0, 1'b1);

    // R6: unsupported size
    read_cycle(MY_ID, 28'h0003210, 4'h1, 1'b1);
    read_cycle(MY_ID, 28'h0003210, 4'hF, 1'b1);

    // R2: start with frame high, and other codes with frame low
    read_cycle(MY_ID, 28'h0002222, 4'h0, 1'b0);
    step(4'h0, 1'b0, 0, 4'h0, 0, '0, "R2 other code");
    step(MY_ID, 1'b1, 0, 4'h0, 0, '0, "R2 other code");
    step(4'hE, 1'b0, 0, 4'h0, 0, '0, "R2 other code");
    step(4'hF, 1'b1, 0, 4'h0, 0, '0, "R2 other code");
    read_cycle(MY_ID, 28'h0002222, 4'h0, 1'b1);

    // Mixed addresses
    lcg = 28'h0BEEF01;
    for (int k = 0; k < 20; k++) begin
      lcg = 28'(lcg * 28'd1103515 + 28'd12345);
      read_cycle(MY_ID, lcg, 4'h0, 1'b1);
    end

    // R1: reset in the middle of the drive window
    step(4'hD, 1'b0, 0, 4'h0, 0, '0, "R2 start");
    step(MY_ID, 1'b1, 0, 4'h0, 0, '0, "R3 select");
    for (int i = 0; i < 7; i++) step(4'h3, 1'b1, 0, 4'h0, 0, '0, "R4 address");
    step(4'h0, 1'b1, 0, 4'h0, 1, AW'(28'h3333333), "R5 strobe");
    step(4'hF, 1'b1, 0, 4'h0, 0, '0, "R7 tar0");
    step(4'hF, 1'b1, 1, 4'hF, 0, '0, "R7 tar1");
    rst_n = 1'b0;
    #1;
    chk("R1 mid reset oe", 32'(bus_oe), 32'd0);
    chk("R1 mid reset rd", 32'(mem_rd), 32'd0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    step(4'hF, 1'b1, 0, 4'h0, 0, '0, "R1 after reset");
    read_cycle(MY_ID, 28'h0007777, 4'h0, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule